// File: doc/BRIEF.md
# Reset Cause and Wakeup Status Controller

This block keeps a record of what caused the latest system reset and what brought the device out of deep power down. Each cause has a sticky flag in a status word. A source event sets its flag, and only software can clear it. The block also lets software request a whole-chip reset or a CPU-core reset by writing a control word. Each request bit is a one-shot: it drops by itself after a fixed number of clocks.

Software uses a simple register bus with two word addresses: status at word 0 and control at word 1. Read data is registered and appears one cycle after the read. The status word is also driven directly on a port, so other logic can see it without a bus read. The block sits in an always-on domain. A software chip-reset request does not reset it, so the recorded cause survives that request. A power-on event wipes the other reset causes and marks itself as the cause.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst` is high, the flags, the one-shot counters and `bus_rdata` return to zero. In the cycle after `rst` is released, `stat_word`, `bus_rdata`, `chip_rst_req` and `cpu_rst_req` are all 0.
- R2: `rst_evt[i]` sets a status bit one cycle later. Index 0 (power-on) sets bit 0, index 1 (reset pin) bit 1, index 2 (watchdog) bit 2, index 3 (low-voltage) bit 3, index 4 (brown-out) bit 4 and index 5 (power management) bit 6. Each bit stays set with no further event.
- R3: A status write (bus_sel=1, bus_wr=1, word address 0) with a 1 in a reset-cause bit clears that bit on the next cycle. A 0 in the written data leaves the bit unchanged.
- R4: When a source event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: A power-on event (`rst_evt[0]`) sets bit 0 and clears bits 1 to 4 and bit 6. Any of those bits whose own event arrives in the same cycle ends up set. The wakeup bits are not changed.
- R6: `wake_evt[0]` (wake or reset pin edge) sets bit 8, `wake_evt[1]` (low-frequency timer) sets bit 9, and `wake_evt[2]` (power-on wake) sets bit 10. Each stays set.
- R7: A status write with bit 8 set clears bits 8, 9 and 10 together. A status write with 1s only in bits 9 or 10 has no effect on them.
- R8: A control write (word address 1) with bit 0 set raises `chip_rst_req`, and one with bit 1 set raises `cpu_rst_req`. The output goes high on the cycle after the write and stays high for exactly 2 cycles, then returns to 0. A further write while the request is high does not extend it. Reading the control word during those cycles returns 1 in that bit.
- R9: The status flags are unchanged while a chip or CPU reset request is active.
- R10: Status bits 5, 7 and 11 to 31 always read 0, and writing 1 to them has no effect.
- R11: A read (bus_sel=1, bus_wr=0) returns, on `bus_rdata` one cycle later, the status word for word address 0, the control word for address 1, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_evt | input | 6 | Reset-cause event pulses: power-on, pin, watchdog, low-voltage, brown-out, power management |
| wake_evt | input | 3 | Wakeup event pulses: pin edge, timer, power-on |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| stat_word | output | DATA_W | Live status word |
| chip_rst_req | output | 1 | Whole-chip reset request |
| cpu_rst_req | output | 1 | CPU-core reset request |

## Verification
The hardest situations to reach are the ones where two events land on the same flag in one clock. The stimulus drives them from the vector table in the same cycle:
- a clear and a set of the same flag;
- a power-on event together with another cause;
- a wakeup-group clear together with a timer wake.

The other hard case is a second control write that arrives while a request is still high. A directed sequence issues it one cycle after the first write and then checks that the request still falls after exactly two cycles.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int N_RST     = 6;
  localparam int N_WAKE    = 3;
  localparam int N_REQ     = 2;
  localparam int WAKE_BASE = 8;
  localparam int POR_IDX   = 0;
  localparam int STAT_ADDR = 0;
  localparam int CTRL_ADDR = 1;

  // reset-cause index to status bit position (bit 5 is skipped)
  function automatic int rst_bit(input int idx);
    return (idx < 5) ? idx : idx + 1;
  endfunction
endpackage

// File: rtl/rsc_sticky.sv
module rsc_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/rsc_oneshot.sv
module rsc_oneshot #(
  parameter int N    = 2,
  parameter int HOLD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fire_i,
  output logic [N-1:0] act_o
);
  localparam int CW = $clog2(HOLD + 1);

  for (genvar g = 0; g < N; g++) begin : g_shot
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)                        cnt_q <= '0;
      else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
      else if (fire_i[g])             cnt_q <= CW'(HOLD);
    end
    assign act_o[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/rsc_readback.sv
module rsc_readback #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] stat_w,
  input  logic [DATA_W-1:0] ctrl_w,
  output logic [DATA_W-1:0] rdata_o
);
  import rsc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd_en) begin
      if (addr == ADDR_W'(STAT_ADDR))      rdata_o <= stat_w;
      else if (addr == ADDR_W'(CTRL_ADDR)) rdata_o <= ctrl_w;
      else                                 rdata_o <= '0;
    end
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rsc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int HOLD_CYC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_RST-1:0]    rst_evt,
  input  logic [N_WAKE-1:0]   wake_evt,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [DATA_W-1:0]   stat_word,
  output logic                chip_rst_req,
  output logic                cpu_rst_req
);
  logic                stat_we, ctrl_we, rd_en;
  logic [N_RST-1:0]    rst_clr, rst_q;
  logic [N_WAKE-1:0]   wake_clr, wake_q;
  logic [N_REQ-1:0]    fire, req_act;
  logic [DATA_W-1:0]   ctrl_word;
  logic                unused_wdata;

  assign stat_we      = bus_sel & bus_wr & (bus_addr == ADDR_W'(STAT_ADDR));
  assign ctrl_we      = bus_sel & bus_wr & (bus_addr == ADDR_W'(CTRL_ADDR));
  assign rd_en        = bus_sel & ~bus_wr;
  assign unused_wdata = ^bus_wdata;

  // write-1 clears; the power-on event also clears the other causes
  for (genvar i = 0; i < N_RST; i++) begin : g_rclr
    if (i == POR_IDX) begin : g_por
      assign rst_clr[i] = stat_we & bus_wdata[rst_bit(i)];
    end else begin : g_oth
      assign rst_clr[i] = (stat_we & bus_wdata[rst_bit(i)]) | rst_evt[POR_IDX];
    end
  end

  // one write bit clears the whole wakeup group
  assign wake_clr = {N_WAKE{stat_we & bus_wdata[WAKE_BASE]}};

  rsc_sticky #(.N(N_RST)) u_rst_flags (
    .clk(clk), .rst(rst), .set_i(rst_evt), .clr_i(rst_clr), .flags_o(rst_q)
  );

  rsc_sticky #(.N(N_WAKE)) u_wake_flags (
    .clk(clk), .rst(rst), .set_i(wake_evt), .clr_i(wake_clr), .flags_o(wake_q)
  );

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < N_RST; i++)  stat_word[rst_bit(i)]   = rst_q[i];
    for (int j = 0; j < N_WAKE; j++) stat_word[WAKE_BASE+j] = wake_q[j];
  end

  assign fire = {N_REQ{ctrl_we}} & bus_wdata[N_REQ-1:0];

  rsc_oneshot #(.N(N_REQ), .HOLD(HOLD_CYC)) u_req (
    .clk(clk), .rst(rst), .fire_i(fire), .act_o(req_act)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[N_REQ-1:0] = req_act;
  end

  assign chip_rst_req = req_act[0];
  assign cpu_rst_req  = req_act[1];

  rsc_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(bus_addr),
    .stat_w(stat_word), .ctrl_w(ctrl_word), .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk
  import rsc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int HOLD_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_RST-1:0]  rst_evt,
  input logic [N_WAKE-1:0] wake_evt,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] stat_word,
  input logic              chip_rst_req,
  input logic              cpu_rst_req
);
  localparam int RW = $clog2(HOLD_CYC + 2);
  logic          wr_stat;
  logic [RW-1:0] run_q;

  assign wr_stat = bus_sel & bus_wr & (bus_addr == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (rst)               run_q <= '0;
    else if (chip_rst_req) run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  p_rst_state_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> stat_word == '0 && !chip_rst_req && !cpu_rst_req);

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    rst_evt[2] |=> stat_word[2]);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stat && bus_wdata[2] && !rst_evt[2] |=> !stat_word[2]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    rst_evt[1] && wr_stat && bus_wdata[1] |=> stat_word[1]);

  p_por_wipe_r5: assert property (@(posedge clk) disable iff (rst)
    rst_evt[POR_IDX] && !rst_evt[3] |=> stat_word[0] && !stat_word[3]);

  p_wake_grp_r7: assert property (@(posedge clk) disable iff (rst)
    wr_stat && bus_wdata[WAKE_BASE] && wake_evt == '0
    |=> stat_word[WAKE_BASE+N_WAKE-1:WAKE_BASE] == '0);

  p_hold_max_r8: assert property (@(posedge clk) disable iff (rst)
    chip_rst_req |-> run_q < RW'(HOLD_CYC));

  p_hold_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(chip_rst_req) |-> run_q == RW'(HOLD_CYC));

  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (chip_rst_req || cpu_rst_req) && !wr_stat && rst_evt == '0 && wake_evt == '0
    |=> $stable(stat_word));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !stat_word[5] && !stat_word[7] && stat_word[DATA_W-1:WAKE_BASE+N_WAKE] == '0);
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .rst_evt(rst_evt), .wake_evt(wake_evt),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .stat_word(stat_word), .chip_rst_req(chip_rst_req), .cpu_rst_req(cpu_rst_req)
);

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [5:0]  rst_evt = '0;
  logic [2:0]  wake_evt = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, stat_word;
  logic        chip_rst_req, cpu_rst_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  rst_cause_ctrl u_dut (
    .clk(clk), .rst(rst), .rst_evt(rst_evt), .wake_evt(wake_evt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_word(stat_word),
    .chip_rst_req(chip_rst_req), .cpu_rst_req(cpu_rst_req)
  );

  // fields: rst_evt[45:40] wake[39:37] wr[36] wdata[35:20] exp[19:4] req[3:0]
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {6'b000001, 3'b000, 1'b0, 16'h0000, 16'h0001, 4'd2},  // R2 power-on
    {6'b000100, 3'b000, 1'b0, 16'h0000, 16'h0005, 4'd2},  // R2 watchdog
    {6'b100000, 3'b000, 1'b0, 16'h0000, 16'h0045, 4'd2},  // R2 power mgmt -> bit 6
    {6'b000000, 3'b000, 1'b1, 16'h0000, 16'h0045, 4'd3},  // R3 write 0 no effect
    {6'b000000, 3'b000, 1'b1, 16'h0004, 16'h0041, 4'd3},  // R3 clear bit 2
    {6'b000100, 3'b000, 1'b1, 16'h0004, 16'h0045, 4'd4},  // R4 set beats clear
    {6'b011010, 3'b000, 1'b0, 16'h0000, 16'h005F, 4'd2},  // R2 pin, lvr, bod
    {6'b000000, 3'b001, 1'b0, 16'h0000, 16'h015F, 4'd6},  // R6 pin wake
    {6'b000000, 3'b110, 1'b0, 16'h0000, 16'h075F, 4'd6},  // R6 timer + por wake
    {6'b000000, 3'b000, 1'b1, 16'h0600, 16'h075F, 4'd7},  // R7 bits 9,10 ignored
    {6'b000000, 3'b000, 1'b1, 16'h0100, 16'h005F, 4'd7},  // R7 group clear
    {6'b000000, 3'b010, 1'b1, 16'h0100, 16'h025F, 4'd4},  // R4 timer wake beats clear
    {6'b000001, 3'b000, 1'b0, 16'h0000, 16'h0201, 4'd5},  // R5 power-on wipes causes
    {6'b000000, 3'b000, 1'b1, 16'hFFFF, 16'h0000, 4'd3},  // R3 clear all
    {6'b000011, 3'b000, 1'b0, 16'h0000, 16'h0003, 4'd5},  // R5 pin with power-on
    {6'b000000, 3'b000, 1'b1, 16'h00A0, 16'h0003, 4'd10}  // R10 unused bits
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst_evt = '0; wake_evt = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_read(input logic [3:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status", stat_word, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 reqs", {30'h0, cpu_rst_req, chip_rst_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      rst_evt   = VEC[i][45:40];
      wake_evt  = VEC[i][39:37];
      bus_sel   = VEC[i][36];
      bus_wr    = VEC[i][36];
      bus_addr  = 4'd0;
      bus_wdata = {16'h0, VEC[i][35:20]};
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), stat_word, {16'h0, VEC[i][19:4]});
    end
    idle();

    // R11 readback
    bus_read(4'd0); @(negedge clk); idle();
    chk("R11 status read", bus_rdata, 32'h3);
    bus_read(4'd5); @(negedge clk); idle();
    chk("R11 unmapped read", bus_rdata, 32'h0);
    bus_read(4'd1); @(negedge clk); idle();
    chk("R11 control read idle", bus_rdata, 32'h0);

    // R8 chip request with a second write that must not extend it
    bus_write(4'd1, 32'h1); @(negedge clk);
    chk("R8 chip high 1", {31'h0, chip_rst_req}, 32'h1);
    chk("R8 cpu low", {31'h0, cpu_rst_req}, 32'h0);
    bus_write(4'd1, 32'h1); @(negedge clk); idle();
    chk("R8 chip high 2", {31'h0, chip_rst_req}, 32'h1);
    @(negedge clk);
    chk("R8 chip low after two", {31'h0, chip_rst_req}, 32'h0);
    chk("R9 flags kept", stat_word, 32'h3);

    // R8 cpu request with control readback
    bus_write(4'd1, 32'h2); @(negedge clk);
    chk("R8 cpu high 1", {31'h0, cpu_rst_req}, 32'h1);
    chk("R8 chip stays low", {31'h0, chip_rst_req}, 32'h0);
    bus_read(4'd1); @(negedge clk); idle();
    chk("R8 control read", bus_rdata, 32'h2);
    chk("R8 cpu high 2", {31'h0, cpu_rst_req}, 32'h1);
    @(negedge clk);
    chk("R8 cpu low after two", {31'h0, cpu_rst_req}, 32'h0);

    // R1 reset mid-run
    rst_evt = 6'b010100; wake_evt = 3'b101; @(negedge clk); idle();
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk("R1 status after reset", stat_word, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule